// File: doc/BRIEF.md
# Address Range Watch Unit

This block watches the transaction traffic of one slave port chosen from a bank of ports. A transaction is a hit when three things hold. Its address lies inside a programmed inclusive window. Its command type is enabled for its master. It arrives on the selected port. The first hit freezes its address, command type and master ID in sticky status registers. Software reads them and clears them with a write. The block only observes: it never stalls or blocks a transaction.

Configuration and status share one small register port. Writes are synchronous and reads are combinational. When neither command type has any master enabled, the watch logic's local enable drops, so the capture registers stop updating. The capture is also presented directly on output ports.

Top module: `addr_watch`

## Requirements
- R1: After reset, every register reads 0, `watch_en_o` is 0 and `hit_valid_o` is 0.
- R2: The select register (address 0, bits [3:0]) chooses the watched port. Codes 0 to NUM_PORTS-1 pick that port; higher codes watch nothing. Traffic on any unselected port never hits.
- R3: The window is inclusive. An address equal to the low threshold (address 1) or the high threshold (address 2) hits. One below low or one above high does not.
- R4: When the low threshold is greater than the high threshold, no address hits.
- R5: Bits [15:0] of the mask register (address 3) enable write commands, one bit per master ID (0x0120 enables IDs 5 and 8). A write from a disabled ID never hits.
- R6: Bits [31:16] of the mask register enable read commands per master ID, independently of the write mask.
- R7: `watch_en_o` is 1 exactly when either mask is nonzero. With both masks zero, no capture occurs.
- R8: A hit presented at a clock edge is visible from that edge on. Register 4 holds the address. Register 5 holds the master ID in bits [3:0], the command type in bit 4 (1 = write, 0 = read) and the valid flag in bit 31. The `hit_*_o` ports show the same values.
- R9: Only the first hit is kept. Later hits leave the status unchanged until it is cleared.
- R10: Any write to register 4 or 5 clears both status registers to 0. A clear wins over a hit at the same edge.
- R11: Registers 0 to 3 read back the last value written to them, masked to their field widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| txn_valid_i | input | NUM_PORTS | Per-port transaction valid |
| txn_addr_i | input | NUM_PORTS*32 | Per-port address, port p in bits [p*32 +: 32] |
| txn_write_i | input | NUM_PORTS | Per-port command type, 1 = write |
| txn_id_i | input | NUM_PORTS*4 | Per-port master ID, port p in bits [p*4 +: 4] |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| watch_en_o | output | 1 | Local enable of the watch logic |
| hit_valid_o | output | 1 | A capture is held |
| hit_addr_o | output | 32 | Captured address |
| hit_write_o | output | 1 | Captured command type |
| hit_id_o | output | 4 | Captured master ID |

## Verification
A register write applied before a rising edge takes effect at that edge. A transaction presented before an edge is captured at that same edge, so status is due one edge after the stimulus. Reads are combinational. The bench drives all inputs at falling edges. It samples status at the next falling edge, one rising edge after the transaction. A register read is compared 1 ns after its index is set, and every miss case is checked at the same point, where a hit would already be visible.

// File: rtl/aw_pkg.sv
package aw_pkg;
  localparam int unsigned AW_ADDR_W = 32;
  localparam int unsigned AW_ID_W   = 4;
  localparam int unsigned AW_SEL_W  = 4;
  localparam int unsigned AW_MASK_W = 1 << AW_ID_W;
  localparam int unsigned AW_RIDX_W = 3;

  localparam logic [AW_RIDX_W-1:0] RIDX_SEL  = 3'd0;
  localparam logic [AW_RIDX_W-1:0] RIDX_LOW  = 3'd1;
  localparam logic [AW_RIDX_W-1:0] RIDX_HIGH = 3'd2;
  localparam logic [AW_RIDX_W-1:0] RIDX_MASK = 3'd3;
  localparam logic [AW_RIDX_W-1:0] RIDX_SADR = 3'd4;
  localparam logic [AW_RIDX_W-1:0] RIDX_SINF = 3'd5;

  typedef struct packed {
    logic [AW_SEL_W-1:0]  sel;
    logic [AW_ADDR_W-1:0] low;
    logic [AW_ADDR_W-1:0] high;
    logic [AW_MASK_W-1:0] wmask;
    logic [AW_MASK_W-1:0] rmask;
  } aw_cfg_t;

  typedef struct packed {
    logic                 valid;
    logic [AW_ADDR_W-1:0] addr;
    logic                 write;
    logic [AW_ID_W-1:0]   id;
  } aw_txn_t;
endpackage

// File: rtl/aw_cfg_regs.sv
module aw_cfg_regs
  import aw_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [AW_RIDX_W-1:0] addr_i,
  input  logic [31:0]          wdata_i,
  output aw_cfg_t              cfg_o,
  output logic                 clr_o
);
  aw_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        RIDX_SEL:  cfg_q.sel  <= wdata_i[AW_SEL_W-1:0];
        RIDX_LOW:  cfg_q.low  <= wdata_i[AW_ADDR_W-1:0];
        RIDX_HIGH: cfg_q.high <= wdata_i[AW_ADDR_W-1:0];
        RIDX_MASK: begin
          cfg_q.wmask <= wdata_i[AW_MASK_W-1:0];
          cfg_q.rmask <= wdata_i[2*AW_MASK_W-1:AW_MASK_W];
        end
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;
  assign clr_o = we_i && (addr_i == RIDX_SADR || addr_i == RIDX_SINF);
endmodule

// File: rtl/aw_port_mux.sv
module aw_port_mux
  import aw_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 9
) (
  input  logic [AW_SEL_W-1:0]            sel_i,
  input  logic [NUM_PORTS-1:0]           valid_i,
  input  logic [NUM_PORTS*AW_ADDR_W-1:0] addr_i,
  input  logic [NUM_PORTS-1:0]           write_i,
  input  logic [NUM_PORTS*AW_ID_W-1:0]   id_i,
  output aw_txn_t                        txn_o
);
  aw_txn_t [NUM_PORTS-1:0] gated;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic pick;
    assign pick = (sel_i == AW_SEL_W'(p));
    assign gated[p].valid = pick & valid_i[p];
    assign gated[p].addr  = pick ? addr_i[p*AW_ADDR_W +: AW_ADDR_W] : '0;
    assign gated[p].write = pick & write_i[p];
    assign gated[p].id    = pick ? id_i[p*AW_ID_W +: AW_ID_W] : '0;
  end

  // codes beyond the port count select nothing
  always_comb begin
    txn_o = '0;
    for (int p = 0; p < NUM_PORTS; p++) txn_o = txn_o | gated[p];
  end
endmodule

// File: rtl/aw_match.sv
module aw_match
  import aw_pkg::*;
(
  input  aw_cfg_t cfg_i,
  input  aw_txn_t txn_i,
  output logic    hit_o
);
  logic in_win, id_ok;
  assign in_win = (txn_i.addr >= cfg_i.low) && (txn_i.addr <= cfg_i.high);
  assign id_ok  = txn_i.write ? cfg_i.wmask[txn_i.id] : cfg_i.rmask[txn_i.id];
  assign hit_o  = txn_i.valid && in_win && id_ok;
endmodule

// File: rtl/aw_capture.sv
module aw_capture
  import aw_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  logic    clr_i,
  input  logic    hit_i,
  input  aw_txn_t txn_i,
  output aw_txn_t stat_o
);
  aw_txn_t stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else if (clr_i) begin
      stat_q <= '0;
    end else if (en_i && hit_i && !stat_q.valid) begin
      stat_q       <= txn_i;
      stat_q.valid <= 1'b1;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/addr_watch.sv
module addr_watch
  import aw_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 9
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_PORTS-1:0]           txn_valid_i,
  input  logic [NUM_PORTS*AW_ADDR_W-1:0] txn_addr_i,
  input  logic [NUM_PORTS-1:0]           txn_write_i,
  input  logic [NUM_PORTS*AW_ID_W-1:0]   txn_id_i,
  input  logic                           reg_we_i,
  input  logic [AW_RIDX_W-1:0]           reg_addr_i,
  input  logic [31:0]                    reg_wdata_i,
  output logic [31:0]                    reg_rdata_o,
  output logic                           watch_en_o,
  output logic                           hit_valid_o,
  output logic [AW_ADDR_W-1:0]           hit_addr_o,
  output logic                           hit_write_o,
  output logic [AW_ID_W-1:0]             hit_id_o
);
  aw_cfg_t cfg;
  aw_txn_t txn, stat;
  logic    clr, hit;
  logic [AW_ADDR_W-1:0] low_q, high_q;

  aw_cfg_regs u_cfg (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cfg_o(cfg), .clr_o(clr)
  );

  aw_port_mux #(.NUM_PORTS(NUM_PORTS)) u_mux (
    .sel_i(cfg.sel), .valid_i(txn_valid_i), .addr_i(txn_addr_i),
    .write_i(txn_write_i), .id_i(txn_id_i), .txn_o(txn)
  );

  aw_match u_match (.cfg_i(cfg), .txn_i(txn), .hit_o(hit));

  assign watch_en_o = |{cfg.wmask, cfg.rmask};

  aw_capture u_cap (
    .clk_i, .rst_ni, .en_i(watch_en_o), .clr_i(clr),
    .hit_i(hit), .txn_i(txn), .stat_o(stat)
  );

  assign low_q  = cfg.low;
  assign high_q = cfg.high;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RIDX_SEL:  reg_rdata_o[AW_SEL_W-1:0] = cfg.sel;
      RIDX_LOW:  reg_rdata_o = cfg.low;
      RIDX_HIGH: reg_rdata_o = cfg.high;
      RIDX_MASK: reg_rdata_o = {cfg.rmask, cfg.wmask};
      RIDX_SADR: reg_rdata_o = stat.addr;
      RIDX_SINF: begin
        reg_rdata_o[31]          = stat.valid;
        reg_rdata_o[AW_ID_W]     = stat.write;
        reg_rdata_o[AW_ID_W-1:0] = stat.id;
      end
      default: ;
    endcase
  end

  assign hit_valid_o = stat.valid;
  assign hit_addr_o  = stat.addr;
  assign hit_write_o = stat.write;
  assign hit_id_o    = stat.id;
endmodule

// File: rtl/addr_watch_chk.sv
module addr_watch_chk
  import aw_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_we_i,
  input logic [AW_RIDX_W-1:0] reg_addr_i,
  input logic                 watch_en_o,
  input logic                 hit_valid_o,
  input logic [AW_ADDR_W-1:0] hit_addr_o,
  input logic                 hit_write_o,
  input logic [AW_ID_W-1:0]   hit_id_o,
  input logic [AW_ADDR_W-1:0] low_q,
  input logic [AW_ADDR_W-1:0] high_q
);
  logic clr_wr;
  assign clr_wr = reg_we_i && (reg_addr_i == RIDX_SADR || reg_addr_i == RIDX_SINF);

  a_r3_capture_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit_valid_o) |-> ($past(low_q) <= hit_addr_o && hit_addr_o <= $past(high_q)));

  a_r7_no_capture_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!watch_en_o && !hit_valid_o) |=> !hit_valid_o);

  a_r9_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_valid_o && !clr_wr) |=> (hit_valid_o && $stable(hit_addr_o) && $stable(hit_id_o)
                                  && $stable(hit_write_o)));

  a_r10_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> !hit_valid_o);

  a_r10_empty_is_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_valid_o |-> (hit_addr_o == '0 && hit_id_o == '0 && !hit_write_o));
endmodule

bind addr_watch addr_watch_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .watch_en_o(watch_en_o), .hit_valid_o(hit_valid_o), .hit_addr_o(hit_addr_o),
  .hit_write_o(hit_write_o), .hit_id_o(hit_id_o), .low_q(low_q), .high_q(high_q)
);

// File: tb/sim_addr_watch.sv
`timescale 1ns/1ps
module sim_addr_watch;
  localparam int NP = 9;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   valid = '0;
  logic [NP*32-1:0] addr = '0;
  logic [NP-1:0]   wr = '0;
  logic [NP*4-1:0] id = '0;
  logic            we = 1'b0;
  logic [2:0]      ra = '0;
  logic [31:0]     wd = '0;
  logic [31:0]     rd;
  logic            wen, hv, hw;
  logic [31:0]     ha;
  logic [3:0]      hid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addr_watch #(.NUM_PORTS(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .txn_valid_i(valid), .txn_addr_i(addr),
    .txn_write_i(wr), .txn_id_i(id), .reg_we_i(we), .reg_addr_i(ra),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .watch_en_o(wen), .hit_valid_o(hv),
    .hit_addr_o(ha), .hit_write_o(hw), .hit_id_o(hid)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; ra = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rchk(string tag, logic [2:0] a, logic [31:0] exp);
    ra = a; #1;
    chk(tag, rd, exp);
  endtask

  task automatic send(int p, logic [31:0] a, logic w, logic [3:0] i);
    @(negedge clk);
    valid = '0; valid[p] = 1'b1; addr[p*32 +: 32] = a; wr[p] = w; id[p*4 +: 4] = i;
    @(negedge clk);
    valid = '0;
  endtask

  task automatic status(string tag, logic v, logic [31:0] a, logic w, logic [3:0] i);
    chk({tag, " valid"}, {31'b0, hv}, {31'b0, v});
    chk({tag, " addr"}, ha, a);
    rchk({tag, " reg4"}, 3'd4, a);
    rchk({tag, " reg5"}, 3'd5, {v, 26'b0, w, i});
  endtask

  task automatic t_reset;
    for (int r = 0; r < 6; r++) rchk("R1 reg", 3'(r), 32'h0);
    chk("R1 watch_en", {31'b0, wen}, 32'h0);
    chk("R1 hit_valid", {31'b0, hv}, 32'h0);
  endtask

  task automatic t_readback;
    wreg(3'd0, 32'hFFFF_FFF2);
    wreg(3'd1, 32'h0000_1000);
    wreg(3'd2, 32'h0000_1FFF);
    rchk("R11 sel", 3'd0, 32'h2);
    rchk("R11 low", 3'd1, 32'h1000);
    rchk("R11 high", 3'd2, 32'h1FFF);
    rchk("R11 mask", 3'd3, 32'h0);
  endtask

  task automatic t_gated;
    send(2, 32'h1500, 1'b1, 4'd5);
    chk("R7 watch_en off", {31'b0, wen}, 32'h0);
    status("R7 no capture", 1'b0, 32'h0, 1'b0, 4'd0);
  endtask

  task automatic t_write_mask;
    wreg(3'd3, 32'h0000_0120);
    chk("R7 watch_en on", {31'b0, wen}, 32'h1);
    send(2, 32'h1500, 1'b1, 4'd4);
    status("R5 disabled id", 1'b0, 32'h0, 1'b0, 4'd0);
    send(2, 32'h1500, 1'b0, 4'd5);
    status("R6 read not enabled", 1'b0, 32'h0, 1'b0, 4'd0);
    send(2, 32'h1000, 1'b1, 4'd5);
    status("R3 R5 R8 low edge", 1'b1, 32'h1000, 1'b1, 4'd5);
    chk("R8 port write", {31'b0, hw}, 32'h1);
    chk("R8 port id", {28'b0, hid}, 32'h5);
  endtask

  task automatic t_first_only;
    send(2, 32'h1800, 1'b1, 4'd8);
    status("R9 later hit ignored", 1'b1, 32'h1000, 1'b1, 4'd5);
    wreg(3'd4, 32'h1234);
    status("R10 clear via reg4", 1'b0, 32'h0, 1'b0, 4'd0);
  endtask

  task automatic t_edges;
    send(2, 32'h0FFF, 1'b1, 4'd8);
    status("R3 below low", 1'b0, 32'h0, 1'b0, 4'd0);
    send(2, 32'h2000, 1'b1, 4'd8);
    status("R3 above high", 1'b0, 32'h0, 1'b0, 4'd0);
    send(2, 32'h1FFF, 1'b1, 4'd8);
    status("R3 high edge", 1'b1, 32'h1FFF, 1'b1, 4'd8);
    wreg(3'd5, 32'h0);
    status("R10 clear via reg5", 1'b0, 32'h0, 1'b0, 4'd0);
  endtask

  task automatic t_read_mask;
    wreg(3'd3, 32'h0008_0120);
    rchk("R11 mask both", 3'd3, 32'h0008_0120);
    send(2, 32'h1500, 1'b1, 4'd3);
    status("R6 write from read-only id", 1'b0, 32'h0, 1'b0, 4'd0);
    send(2, 32'h1500, 1'b0, 4'd3);
    status("R6 read hit", 1'b1, 32'h1500, 1'b0, 4'd3);
    wreg(3'd4, 32'h0);
  endtask

  task automatic t_select;
    send(3, 32'h1500, 1'b1, 4'd5);
    status("R2 other port", 1'b0, 32'h0, 1'b0, 4'd0);
    wreg(3'd0, 32'h8);
    send(8, 32'h1ABC, 1'b1, 4'd8);
    status("R2 port 8", 1'b1, 32'h1ABC, 1'b1, 4'd8);
    wreg(3'd4, 32'h0);
    wreg(3'd0, 32'h9);
    for (int p = 0; p < NP; p++) begin
      send(p, 32'h1500, 1'b1, 4'd5);
    end
    status("R2 code 9 watches nothing", 1'b0, 32'h0, 1'b0, 4'd0);
  endtask

  task automatic t_inverted;
    wreg(3'd0, 32'h2);
    wreg(3'd1, 32'h3000);
    wreg(3'd2, 32'h2000);
    send(2, 32'h2800, 1'b1, 4'd5);
    status("R4 low above high mid", 1'b0, 32'h0, 1'b0, 4'd0);
    send(2, 32'h2000, 1'b1, 4'd5);
    status("R4 low above high edge", 1'b0, 32'h0, 1'b0, 4'd0);
  endtask

  task automatic t_clear_collision;
    wreg(3'd1, 32'h1000);
    wreg(3'd2, 32'h1FFF);
    @(negedge clk);
    valid = '0; valid[2] = 1'b1; addr[2*32 +: 32] = 32'h1100; wr[2] = 1'b1; id[2*4 +: 4] = 4'd5;
    we = 1'b1; ra = 3'd5; wd = 32'h0;
    @(negedge clk);
    valid = '0; we = 1'b0;
    status("R10 clear beats hit", 1'b0, 32'h0, 1'b0, 4'd0);
    wreg(3'd3, 32'h0);
    chk("R7 masks zero again", {31'b0, wen}, 32'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_gated();
    t_write_mask();
    t_first_only();
    t_edges();
    t_read_mask();
    t_select();
    t_inverted();
    t_clear_collision();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule